// File: doc/BRIEF.md
# Indirect Internal Register Access Port

This block opens a window from a 32-bit host register bus onto a small internal register space of 64 words. The internal words are not directly visible to the host. Software reaches them through four directly addressed host registers. It writes a mode/address word that selects the kind of access and the internal index. For a write, it places the data word first. It then sets and clears a start bit, and for a read it collects the result from a read-data register.

The internal space is guarded by a write lock. Until the unlock key is written to internal index 0, every internal write aimed at any other index is dropped. The block holds the host-side decode, the access sequencer, and a model internal register file that stands in for the real target during test.

Top module: `ipx_port`

## Requirements
- R1: After reset every mapped host register reads zero, every internal word is zero and the write lock is engaged.
- R2: Host offsets are 0x016 (start, bit 0), 0x018 (mode/address: bits 5:0 internal index, bit 8 = 1 for read, 0 for write), 0x01A (write data) and 0x01C (read data). The first three read back what was last written, limited to their defined bits.
- R3: A 0-to-1 change of start bit 0 with mode bit 8 = 0 stores the write-data register into the selected internal word, subject to the lock.
- R4: A 0-to-1 change of start bit 0 with mode bit 8 = 1 loads the selected internal word into the read-data register, readable from the next host read.
- R5: Writing start bit 0 = 1 while it is already 1 launches no further access; only a rising edge does.
- R6: While locked, internal writes to indices 1..63 are ignored. Index 0 is always writable, and writing 0xA5000000 there unlocks the space.
- R7: The unlock persists, whatever is later written to index 0, until reset, which engages the lock again.
- R8: The read-data register keeps its value through write accesses and any other host traffic until the next read access.
- R9: Host reads of offsets other than the four mapped ones return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Host write strobe, one cycle per write |
| bus_addr | input | 12 | Host register offset |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data for bus_addr (combinational) |

## Verification
A wrong lock state appears only indirectly. A dropped or wrongly accepted internal write shows up at the next read access of that index, one start pulse later, as a wrong value at offset 0x01C. A missed or repeated launch shows at once: a repeated write with changed data overwrites the stored word, and a spurious read replaces the held read data. The checks therefore pair each write path with a read back through the port, and they probe the read-data register after unrelated writes.

// File: rtl/ipx_pkg.sv
// Shared constants and types for the indirect register access port.
// Assumes a 12-bit host offset space and 32-bit data on both sides.
package ipx_pkg;
    localparam int          HOST_AW    = 12;
    localparam int          DW         = 32;
    localparam int          RW_BIT     = 8;
    localparam logic [11:0] OFF_START  = 12'h016;
    localparam logic [11:0] OFF_MODE   = 12'h018;
    localparam logic [11:0] OFF_WDATA  = 12'h01A;
    localparam logic [11:0] OFF_RDATA  = 12'h01C;
    localparam logic [31:0] UNLOCK_KEY = 32'hA500_0000;

    typedef enum logic {ACC_WRITE = 1'b0, ACC_READ = 1'b1} acc_kind_e;
endpackage

// File: rtl/ipx_host_regs.sv
// Host-side register decode and access sequencer.
// Assumes one-cycle write strobes and combinational host reads.
// Launches one internal access on each rising edge of start bit 0.
module ipx_host_regs
    import ipx_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [HOST_AW-1:0]  bus_addr,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    output logic                acc_go,
    output acc_kind_e           acc_kind,
    output logic [ADDR_W-1:0]   acc_addr,
    output logic [DW-1:0]       acc_wdata,
    input  logic [DW-1:0]       acc_rdata
);
    logic              start_q;
    acc_kind_e         kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DW-1:0]     wdata_q;
    logic [DW-1:0]     rdata_q;
    logic              wr_start, wr_mode, wr_wdata;

    // Decode which host register a write targets.
    always_comb begin
        wr_start = bus_wr && (bus_addr == OFF_START);
        wr_mode  = bus_wr && (bus_addr == OFF_MODE);
        wr_wdata = bus_wr && (bus_addr == OFF_WDATA);
    end

    // Launch only on a 0-to-1 change of the start bit.
    assign acc_go    = wr_start && bus_wdata[0] && !start_q;
    assign acc_kind  = kind_q;
    assign acc_addr  = addr_q;
    assign acc_wdata = wdata_q;

    // Host-visible register state and read-result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            kind_q  <= ACC_WRITE;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (wr_start) start_q <= bus_wdata[0];
            if (wr_mode) begin
                kind_q <= acc_kind_e'(bus_wdata[RW_BIT]);
                addr_q <= bus_wdata[ADDR_W-1:0];
            end
            if (wr_wdata) wdata_q <= bus_wdata;
            if (acc_go && kind_q == ACC_READ) rdata_q <= acc_rdata;
        end
    end

    // Host read multiplexer; unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_START: bus_rdata[0] = start_q;
            OFF_MODE: begin
                bus_rdata[RW_BIT]     = kind_q;
                bus_rdata[ADDR_W-1:0] = addr_q;
            end
            OFF_WDATA: bus_rdata = wdata_q;
            OFF_RDATA: bus_rdata = rdata_q;
            default:   bus_rdata = '0;
        endcase
    end

    // R5
    launch_sets_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_go |=> start_q);
    // R4
    read_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_go && kind_q == ACC_READ) |=> (rdata_q == $past(acc_rdata)));
    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_go && kind_q == ACC_READ) |=> $stable(rdata_q));
endmodule

// File: rtl/ipx_regfile.sv
// Model internal register file with a write lock.
// Assumes accesses arrive as single-cycle launch pulses.
// Index 0 is always writable; the unlock key there opens the rest.
module ipx_regfile
    import ipx_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  acc_kind_e         kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DW-1:0] mem [DEPTH];
    logic          unlocked_q;
    logic          wr_req, wr_ok;

    // Qualify a write against the lock.
    always_comb begin
        wr_req = go && (kind == ACC_WRITE);
        wr_ok  = wr_req && ((addr == '0) || unlocked_q);
    end

    // Storage update and sticky unlock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlocked_q <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (wr_ok) mem[addr] <= wdata;
            if (wr_req && addr == '0 && wdata == UNLOCK_KEY) unlocked_q <= 1'b1;
        end
    end

    // Combinational read of the selected word.
    assign rdata = mem[addr];

    // R6
    locked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !unlocked_q && addr != '0) |=> (mem[$past(addr)] == $past(mem[addr])));
    // R6
    key_unlocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && addr == '0 && wdata == UNLOCK_KEY) |=> unlocked_q);
    // R7
    unlock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unlocked_q |=> unlocked_q);
endmodule

// File: rtl/ipx_port.sv
// Indirect internal register access port, top level.
// Assumes a single host master issuing one-cycle writes.
module ipx_port
    import ipx_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_wr,
    input  logic [11:0]  bus_addr,
    input  logic [31:0]  bus_wdata,
    output logic [31:0]  bus_rdata
);
    logic              go;
    acc_kind_e         kind;
    logic [ADDR_W-1:0] iaddr;
    logic [DW-1:0]     iwdata, irdata;

    ipx_host_regs #(.ADDR_W(ADDR_W)) u_host (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .acc_go(go),
        .acc_kind(kind), .acc_addr(iaddr), .acc_wdata(iwdata), .acc_rdata(irdata)
    );

    ipx_regfile #(.ADDR_W(ADDR_W)) u_rf (
        .clk(clk), .rst_n(rst_n), .go(go), .kind(kind), .addr(iaddr),
        .wdata(iwdata), .rdata(irdata)
    );
endmodule

// File: tb/sim_ipx_port.sv
`timescale 1ns/1ps
module sim_ipx_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    ipx_port u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
                 .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

    localparam logic [5:0]  VADDR [6] = '{6'd1, 6'd63, 6'd17, 6'd32, 6'd2, 6'd40};
    localparam logic [31:0] VDATA [6] = '{32'h1234_5678, 32'hFFFF_FFFF, 32'h0000_0001,
                                          32'h8000_0000, 32'hDEAD_BEEF, 32'h0F0F_A5A5};

    task automatic hwrite(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic hread(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic iwrite(input logic [5:0] a, input logic [31:0] d);
        hwrite(12'h018, {23'd0, 1'b0, 2'b00, a});
        hwrite(12'h01A, d);
        hwrite(12'h016, 32'd1);
        hwrite(12'h016, 32'd0);
    endtask

    task automatic iread(input logic [5:0] a, output logic [31:0] d);
        hwrite(12'h018, {23'd0, 1'b1, 2'b00, a});
        hwrite(12'h016, 32'd1);
        hwrite(12'h016, 32'd0);
        hread(12'h01C, d);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        logic [31:0] v;
        do_reset();
        // R1: reset state
        hread(12'h016, v); check("R1 start", v, 0);
        hread(12'h018, v); check("R1 mode", v, 0);
        hread(12'h01A, v); check("R1 wdata", v, 0);
        hread(12'h01C, v); check("R1 rdata", v, 0);
        // R2: readback of defined bits only
        hwrite(12'h018, 32'hFFFF_FFFF); hread(12'h018, v); check("R2 mode", v, 32'h0000_013F);
        hwrite(12'h01A, 32'hCAFE_0001); hread(12'h01A, v); check("R2 wdata", v, 32'hCAFE_0001);
        hwrite(12'h016, 32'hFFFF_FFFE); hread(12'h016, v); check("R2 start", v, 0);
        // R6: locked write dropped, index 0 writable
        iwrite(6'd5, 32'h5555_AAAA);
        iread(6'd5, v); check("R6 locked drop", v, 0);
        iwrite(6'd0, 32'h0000_0042);
        iread(6'd0, v); check("R6 idx0 writable", v, 32'h0000_0042);
        iwrite(6'd0, 32'hA500_0000);
        iread(6'd0, v); check("R6 key stored", v, 32'hA500_0000);
        // R7: unlock survives other index-0 writes
        iwrite(6'd0, 32'h0000_0000);
        // R3/R4: vector table after unlock
        for (int i = 0; i < 6; i++) iwrite(VADDR[i], VDATA[i]);
        for (int i = 0; i < 6; i++) begin
            iread(VADDR[i], v);
            check("R3 R4 vector", v, VDATA[i]);
        end
        // R8: write access keeps read data
        iwrite(6'd9, 32'h1111_2222);
        hread(12'h01C, v); check("R8 hold", v, VDATA[5]);
        // R5: second start=1 without a 0 in between is no new access
        hwrite(12'h018, {23'd0, 1'b0, 2'b00, 6'd7});
        hwrite(12'h01A, 32'hAAAA_0001);
        hwrite(12'h016, 32'd1);
        hwrite(12'h01A, 32'hBBBB_0002);
        hwrite(12'h016, 32'd1);
        hwrite(12'h016, 32'd0);
        iread(6'd7, v); check("R5 no relaunch", v, 32'hAAAA_0001);
        // R9: unmapped offsets
        hread(12'h000, v); check("R9 0x000", v, 0);
        hread(12'h014, v); check("R9 0x014", v, 0);
        hread(12'h01E, v); check("R9 0x01E", v, 0);
        // R7: reset re-engages lock
        do_reset();
        iread(6'd9, v); check("R1 mem cleared", v, 0);
        iwrite(6'd9, 32'h7777_7777);
        iread(6'd9, v); check("R7 relocked", v, 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule